// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block decides, for each incoming Ethernet frame, whether the frame is kept or dropped. It looks only at the 48-bit destination address. The address arrives together with a one-cycle strobe. The block holds sixteen programmable address entries, and each entry can be switched on or off on its own. A five-bit mode word sets the filtering policy.

Each destination address is sorted into one of three classes: broadcast, multicast or unicast. Each class has its own accept bit. The address is also compared against the enabled table entries. That table result takes part in the decision only while table comparison is switched on. It can be inverted, so that the block keeps only frames that match no enabled entry.

One clock after the strobe, the block reports three things: the accept or reject verdict, a flag that says whether any enabled entry matched, and the index of the lowest-numbered matching entry. Software programs the block through a simple write-only register port.

Top module: `rxaddr_filter`

## Requirements
- R1: After a synchronous reset, the mode word, the entry enables and all entry addresses are zero. Every frame is then rejected, the match flag reads 0 and `res_valid` is low until a strobe arrives.
- R2: `res_valid` is high exactly in the cycle after a cycle with `da_valid` high. `accept`, `match_hit` and `match_idx` change only in that cycle and hold their values otherwise.
- R3: With mode bit 2 set, an all-ones address is accepted whatever the table holds.
- R4: With mode bit 1 set, a multicast address is accepted. A multicast address has bit 40 of `da` set (bit 0 of the first octet, where `da[47:40]` is the first octet) and is not all ones. Mode bit 0 alone does not accept it.
- R5: With mode bit 0 set, a unicast address is accepted. A unicast address has `da[40]` clear. Mode bits 1 and 2 alone do not accept it.
- R6: With mode bit 4 set, an address equal to an enabled entry is accepted. Entry k holds `da[47:16]` in register 2+2k and `da[15:0]` in bits 31:16 of register 3+2k.
- R7: An entry whose bit in the enable register (address 1, bit k) is clear never matches, even when its stored address is equal.
- R8: With mode bit 4 clear, the table result plays no part in acceptance.
- R9: With mode bits 4 and 3 both set, the table result is inverted. An address that matches no enabled entry is accepted, and one that matches an enabled entry is accepted only through a class bit.
- R10: `match_hit` reports a match against any enabled entry, independent of mode bits 4 and 3. `match_idx` gives the lowest matching index, or 0 when nothing matches.
- R11: An all-ones address counts as broadcast only. Mode bit 1 alone rejects it.
- R12: The mode word is at address 0 (bits 4:0), and writes to addresses 34 and above change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register word address |
| wr_data | input | 32 | Register write data |
| da_valid | input | 1 | Destination address valid strobe |
| da | input | 48 | Destination address, first octet in bits 47:40 |
| res_valid | output | 1 | Verdict valid, one cycle after `da_valid` |
| accept | output | 1 | 1 = keep frame |
| match_hit | output | 1 | Some enabled entry matched |
| match_idx | output | 4 | Lowest matching entry index |

## Verification
The assertions assume two things about the inputs: `da_valid` is a plain single-cycle pulse, and a register write landing in the strobe cycle does not count for that frame. The stimulus separates every register write from the following strobe by at least one idle cycle. It also drives each strobe for exactly one cycle, so that any value held in the result registers is observable before the next frame. The table is loaded with duplicate and disabled entries so that the priority and enable rules can be told apart.

// File: rtl/rxaf_pkg.sv
// Shared constants for the receive address filter.
// Assumes at most 32 table entries, so the enable mask fits one register word.
package rxaf_pkg;
    localparam int MAC_W   = 48;
    localparam int WORD_W  = 32;
    localparam int LOW_W   = MAC_W - WORD_W;   // address bits kept in the low register
    localparam int MODE_W  = 5;
    // Mode word bit positions
    localparam int M_UCAST  = 0;
    localparam int M_MCAST  = 1;
    localparam int M_BCAST  = 2;
    localparam int M_INVERT = 3;
    localparam int M_TABLE  = 4;
    // Fixed register slots
    localparam int A_MODE   = 0;
    localparam int A_ENABLE = 1;
    localparam int A_TABLE  = 2;
endpackage

// File: rtl/rxaf_regs.sv
// Register bank: mode word, per-entry enable mask and entry addresses.
// Assumes single-word writes; writes outside the decoded range are dropped.
module rxaf_regs #(
    parameter int NUM_ENT = 16,
    parameter int WA_W    = 6
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_en,
    input  logic [WA_W-1:0]                      wr_addr,
    input  logic [rxaf_pkg::WORD_W-1:0]          wr_data,
    output logic [rxaf_pkg::MODE_W-1:0]          mode,
    output logic [NUM_ENT-1:0]                   ent_en,
    output logic [NUM_ENT-1:0][rxaf_pkg::MAC_W-1:0] ent_mac
);
    import rxaf_pkg::*;

    localparam logic [WA_W-1:0] ADR_MODE = WA_W'(A_MODE);
    localparam logic [WA_W-1:0] ADR_EN   = WA_W'(A_ENABLE);

    // Mode word and enable mask updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode   <= '0;
            ent_en <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADR_MODE) mode   <= wr_data[MODE_W-1:0];
            if (wr_addr == ADR_EN)   ent_en <= wr_data[NUM_ENT-1:0];
        end
    end

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
        localparam logic [WA_W-1:0] ADR_HI = WA_W'(A_TABLE + 2*k);
        localparam logic [WA_W-1:0] ADR_LO = WA_W'(A_TABLE + 2*k + 1);
        logic [WORD_W-1:0] hi_q;
        logic [LOW_W-1:0]  lo_q;

        // Entry k: upper word holds first four octets, lower word top half the last two
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hi_q <= '0;
                lo_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == ADR_HI) hi_q <= wr_data;
                if (wr_addr == ADR_LO) lo_q <= wr_data[WORD_W-1 -: LOW_W];
            end
        end

        assign ent_mac[k] = {hi_q, lo_q};
    end
endmodule

// File: rtl/rxaf_match.sv
// Compare bank: equality of the address against every enabled entry,
// followed by a lowest-index-wins priority encoder. Purely combinational.
module rxaf_match #(
    parameter int NUM_ENT = 16,
    parameter int IDX_W   = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic [rxaf_pkg::MAC_W-1:0]           da,
    input  logic [NUM_ENT-1:0]                   ent_en,
    input  logic [NUM_ENT-1:0][rxaf_pkg::MAC_W-1:0] ent_mac,
    output logic                                 hit,
    output logic [IDX_W-1:0]                     hit_idx
);
    logic [NUM_ENT-1:0] eq;

    for (genvar k = 0; k < NUM_ENT; k++) begin : g_cmp
        assign eq[k] = ent_en[k] && (ent_mac[k] == da);
    end

    // Lowest matching index wins
    always_comb begin
        hit_idx = '0;
        for (int i = NUM_ENT - 1; i >= 0; i--) begin
            if (eq[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit = |eq;

    AST_HIT_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ent_en[hit_idx]);                                          // R7
    AST_HIT_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (ent_mac[hit_idx] == da));                                 // R10
endmodule

// File: rtl/rxaf_decide.sv
// Classifies the address and combines class bits with the table result.
// Assumes da_valid is a single-cycle pulse; the verdict registers load only on it.
module rxaf_decide #(
    parameter int IDX_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         da_valid,
    input  logic [rxaf_pkg::MAC_W-1:0]   da,
    input  logic [rxaf_pkg::MODE_W-1:0]  mode,
    input  logic                         hit,
    input  logic [IDX_W-1:0]             hit_idx,
    output logic                         res_valid,
    output logic                         accept,
    output logic                         match_hit,
    output logic [IDX_W-1:0]             match_idx
);
    import rxaf_pkg::*;

    localparam int GRP_BIT = MAC_W - 8;   // bit 0 of the first octet

    logic is_bc, is_mc, is_uc, tbl_ok, verdict;

    // Address class decode
    always_comb begin
        is_bc = &da;
        is_mc = da[GRP_BIT] && !is_bc;
        is_uc = !da[GRP_BIT];
    end

    // Table result after optional inversion, then the accept equation
    always_comb begin
        tbl_ok  = mode[M_TABLE] && (hit ^ mode[M_INVERT]);
        verdict = (is_bc && mode[M_BCAST]) || (is_mc && mode[M_MCAST]) ||
                  (is_uc && mode[M_UCAST]) || tbl_ok;
    end

    // Verdict registers, loaded on the strobe only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            accept    <= 1'b0;
            match_hit <= 1'b0;
            match_idx <= '0;
        end else begin
            res_valid <= da_valid;
            if (da_valid) begin
                accept    <= verdict;
                match_hit <= hit;
                match_idx <= hit_idx;
            end
        end
    end

    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |-> $onehot({is_bc, is_mc, is_uc}));                      // R11
endmodule

// File: rtl/rxaddr_filter.sv
// Receive destination address filter top: register bank, compare bank and
// decision stage. Verdict appears one clock after the address strobe.
module rxaddr_filter #(
    parameter int NUM_ENT = 16,
    localparam int IDX_W  = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1,
    localparam int WA_W   = $clog2(rxaf_pkg::A_TABLE + 2*NUM_ENT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [WA_W-1:0]             wr_addr,
    input  logic [31:0]                 wr_data,
    input  logic                        da_valid,
    input  logic [47:0]                 da,
    output logic                        res_valid,
    output logic                        accept,
    output logic                        match_hit,
    output logic [IDX_W-1:0]            match_idx
);
    import rxaf_pkg::*;

    logic [MODE_W-1:0]              mode;
    logic [NUM_ENT-1:0]             ent_en;
    logic [NUM_ENT-1:0][MAC_W-1:0]  ent_mac;
    logic                           hit;
    logic [IDX_W-1:0]               hit_idx;

    rxaf_regs #(.NUM_ENT(NUM_ENT), .WA_W(WA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .mode(mode), .ent_en(ent_en), .ent_mac(ent_mac)
    );

    rxaf_match #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_match (
        .clk(clk), .rst_n(rst_n), .da(da), .ent_en(ent_en), .ent_mac(ent_mac),
        .hit(hit), .hit_idx(hit_idx)
    );

    rxaf_decide #(.IDX_W(IDX_W)) u_decide (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da), .mode(mode),
        .hit(hit), .hit_idx(hit_idx), .res_valid(res_valid), .accept(accept),
        .match_hit(match_hit), .match_idx(match_idx)
    );

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid |=> res_valid);                                           // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> !res_valid);                                         // R2
    AST_HOLD_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !da_valid |=> $stable(accept) && $stable(match_idx));              // R2
    AST_MODE_OFF_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        da_valid && (mode == '0) |=> !accept);                             // R1
endmodule

// File: tb/rxaddr_filter_test.sv
module rxaddr_filter_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [4:0]  mode;
        logic [47:0] mac;
        logic        acc;
        logic        hit;
        logic [3:0]  idx;
        logic [3:0]  req;
    } vec_t;

    // Table: entries 0,3,5,15 enabled; 3 and 5 hold the same address; 7 disabled
    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{5'h00, 48'h020000000001, 1'b0, 1'b1, 4'd0,  4'd8},   // R8
        '{5'h10, 48'h020000000001, 1'b1, 1'b1, 4'd0,  4'd6},   // R6
        '{5'h10, 48'h020000000005, 1'b1, 1'b1, 4'd3,  4'd10},  // R10
        '{5'h10, 48'h020000000009, 1'b0, 1'b0, 4'd0,  4'd7},   // R7
        '{5'h18, 48'h020000000009, 1'b1, 1'b0, 4'd0,  4'd9},   // R9
        '{5'h18, 48'h020000000001, 1'b0, 1'b1, 4'd0,  4'd9},   // R9
        '{5'h04, 48'hFFFFFFFFFFFF, 1'b1, 1'b0, 4'd0,  4'd3},   // R3
        '{5'h02, 48'hFFFFFFFFFFFF, 1'b0, 1'b0, 4'd0,  4'd11},  // R11
        '{5'h02, 48'h01005E000001, 1'b1, 1'b0, 4'd0,  4'd4},   // R4
        '{5'h01, 48'h01005E000001, 1'b0, 1'b0, 4'd0,  4'd4},   // R4
        '{5'h01, 48'h0A1122334455, 1'b1, 1'b0, 4'd0,  4'd5},   // R5
        '{5'h06, 48'h0A1122334455, 1'b0, 1'b0, 4'd0,  4'd5},   // R5
        '{5'h10, 48'h01005E0000FB, 1'b1, 1'b1, 4'd15, 4'd6},   // R6
        '{5'h08, 48'h020000000009, 1'b0, 1'b0, 4'd0,  4'd8}    // R8
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        da_valid = 1'b0;
    logic [47:0] da = '0;
    logic        res_valid, accept, match_hit;
    logic [3:0]  match_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    rxaddr_filter uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .da_valid(da_valid), .da(da), .res_valid(res_valid),
        .accept(accept), .match_hit(match_hit), .match_idx(match_idx)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 20000", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_entry(input int k, input logic [47:0] m);
        wr(6'(2 + 2*k), m[47:16]);
        wr(6'(3 + 2*k), {m[15:0], 16'hBEEF});
    endtask

    // Strobe one address; verdict checked one cycle later, hold checked after that
    task automatic frame(input logic [47:0] m, input logic e_acc, input logic e_hit,
                         input logic [3:0] e_idx, input string req);
        logic held;
        @(negedge clk);
        da_valid = 1'b1; da = m;
        @(negedge clk);
        da_valid = 1'b0; da = ~m;
        chk(res_valid === 1'b1, "R2", "res_valid after strobe", 64'(res_valid), 64'd1);
        chk(accept === e_acc, req, "accept", 64'(accept), 64'(e_acc));
        chk(match_hit === e_hit, req, "match_hit", 64'(match_hit), 64'(e_hit));
        chk(match_idx === e_idx, req, "match_idx", 64'(match_idx), 64'(e_idx));
        held = accept;
        @(negedge clk);
        chk(res_valid === 1'b0, "R2", "res_valid idle", 64'(res_valid), 64'd0);
        chk(accept === held, "R2", "accept held", 64'(accept), 64'(held));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(res_valid === 1'b0 && accept === 1'b0, "R1", "reset outputs",
            64'({res_valid, accept}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res_valid === 1'b0, "R1", "no valid without strobe", 64'(res_valid), 64'd0);

        // Program the table
        set_entry(0,  48'h020000000001);
        set_entry(3,  48'h020000000005);
        set_entry(5,  48'h020000000005);
        set_entry(7,  48'h020000000009);
        set_entry(15, 48'h01005E0000FB);
        wr(6'd1, 32'h0000_8029);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            wr(6'd0, {27'd0, VEC[i].mode});
            frame(VEC[i].mac, VEC[i].acc, VEC[i].hit, VEC[i].idx,
                  $sformatf("R%0d", VEC[i].req));
        end

        // Enabling entry 7 makes it match
        wr(6'd0, 32'h10);
        wr(6'd1, 32'h0000_80A9);
        frame(48'h020000000009, 1'b1, 1'b1, 4'd7, "R7");

        // R12: out-of-range writes leave mode word untouched
        wr(6'd0, 32'h0);
        wr(6'd34, 32'h1F);
        wr(6'd40, 32'h1F);
        wr(6'd63, 32'h1F);
        frame(48'hFFFFFFFFFFFF, 1'b0, 1'b0, 4'd0, "R12");
        frame(48'h020000000001, 1'b0, 1'b1, 4'd0, "R12");

        // R1: reset mid-run clears mode, enables and entries
        wr(6'd0, 32'h1F);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        frame(48'hFFFFFFFFFFFF, 1'b0, 1'b0, 4'd0, "R1");
        frame(48'h020000000001, 1'b0, 1'b0, 4'd0, "R1");
        wr(6'd1, 32'h0000_0001);
        frame(48'h000000000000, 1'b0, 1'b1, 4'd0, "R1");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule